// File: doc/BRIEF.md
# Asynchronous Bus Transfer-Acknowledge Generator

This block is the slave-side responder on a strobe-driven, fully handshaked bus. It runs on the system clock. It samples the active-low address strobe and the two active-low byte strobes through two-flop synchronizers. When a cycle starts, it latches the configuration of the region that the external decoder selects. It then counts that region's wait clocks and drives an active-low transfer acknowledge. The acknowledge stays low until the master releases every strobe. The block waits one clock with all strobes seen high before it accepts the next cycle.

Each of the four regions has a run-time writable wait count and a flag that marks the region as unmapped. One board can therefore be retuned for a different master clock rate without any change to the logic. An unmapped region never acknowledges. In that case a watchdog raises an active-low bus error after a fixed timeout. The block also gives the slave the byte lanes that the cycle uses.

Top module: `bus_ack_gen`

## Requirements
- R1: After reset, dtackN and berrN are high and laneUpper and laneLower are low.
- R2: While a cycle is waiting or acknowledged, laneUpper is 1 exactly when udsN is low and laneLower is 1 exactly when ldsN is low. Upper strobe alone selects the upper byte, lower strobe alone selects the lower byte, and both strobes select a word.
- R3: For a region with a wait count of 0, dtackN goes low after the 4th rising clock edge following the fall of asN. Edges are counted from 1 at the first edge after the change.
- R4: For a region with wait count W, dtackN goes low after edge 4+W and is still high after edge 3+W.
- R5: A clock edge with cfgWe high stores cfgWait and cfgUnmapped into region cfgIdx. Every region resets to wait count 0 and mapped. Cycles that start after the write use the new value.
- R6: Once low, dtackN stays low while any of asN, udsN or ldsN is low. It goes high after the 3rd edge following the release of the last strobe.
- R7: A region marked unmapped never asserts dtackN. berrN goes low after edge 3+TIMEOUT (67 for the default 64) following the fall of asN.
- R8: berrN stays low while asN is low. It goes high after the 3rd edge following the rise of asN, whatever the data strobes do.
- R9: dtackN and berrN are never low at the same time. If the timeout is reached before the wait count, the bus error is raised and no acknowledge follows.
- R10: After an acknowledge ends, a new cycle whose asN falls right after dtackN rises is acknowledged with the normal R3/R4 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| asN | input | 1 | Address strobe, active low, asynchronous |
| udsN | input | 1 | Upper byte strobe, active low, asynchronous |
| ldsN | input | 1 | Lower byte strobe, active low, asynchronous |
| regionSel | input | 2 | Decoded region of the current address, valid while asN is low |
| cfgWe | input | 1 | Write enable for the region configuration table |
| cfgIdx | input | 2 | Region written by cfgWe |
| cfgWait | input | 4 | Wait count to store |
| cfgUnmapped | input | 1 | 1 marks the region as never acknowledging |
| dtackN | output | 1 | Transfer acknowledge, active low |
| berrN | output | 1 | Bus error, active low |
| laneUpper | output | 1 | Upper byte lane in use |
| laneLower | output | 1 | Lower byte lane in use |

## Verification
Every result has a fixed latency. A strobe change needs two edges to pass the synchronizers and one more to reach the state register. The acknowledge is therefore due after edge 4+W, its release after edge 3 from the last strobe rise, and the bus error after edge 3+TIMEOUT. The bench drives inputs on falling edges and counts rising edges from that point. It samples both the edge before a result is due, to see the old value, and the edge at which it is due, to see the new value. Acknowledge/bus-error exclusivity is watched on every falling edge across all scenarios.

// File: rtl/bus_ack_pkg.sv
package bus_ack_pkg;
  localparam int NUM_REGIONS = 4;
  localparam int REGION_W    = $clog2(NUM_REGIONS);
  localparam int WAIT_W      = 4;
  localparam int TIMEOUT     = 64;
  localparam int CNT_W       = $clog2(TIMEOUT);

  typedef struct packed {
    logic              unmapped;
    logic [WAIT_W-1:0] waitCount;
  } regionCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;   // latch region entry, clear counter
    logic count;   // advance elapsed counter
    logic laneEn;  // cycle in progress, drive lanes
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ACK, ST_BERR, ST_RECOVER
  } busState_t;
endpackage

// File: rtl/bus_ack_datapath.sv
module bus_ack_datapath
  import bus_ack_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                asN,
  input  logic                udsN,
  input  logic                ldsN,
  input  logic [REGION_W-1:0] regionSel,
  input  logic                cfgWe,
  input  logic [REGION_W-1:0] cfgIdx,
  input  logic [WAIT_W-1:0]   cfgWait,
  input  logic                cfgUnmapped,
  input  ctrlStrobe_t         ctl,
  output logic                asSync,
  output logic                dsIdle,
  output regionCfg_t          curEntry,
  output logic [CNT_W-1:0]    elapsed,
  output logic                laneUpper,
  output logic                laneLower
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [2:0] syncA, syncB;  // {as, uds, lds}
  regionCfg_t cfgTable [NUM_REGIONS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 3'b111;
      syncB <= 3'b111;
    end else begin
      syncA <= {asN, udsN, ldsN};
      syncB <= syncA;
    end
  end

  assign asSync = syncB[2];
  assign dsIdle = syncB[1] & syncB[0];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgTable[g] <= '0;
      end else if (cfgWe && cfgIdx == REGION_W'(g)) begin
        cfgTable[g] <= '{unmapped: cfgUnmapped, waitCount: cfgWait};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curEntry <= '0;
      elapsed  <= '0;
    end else if (ctl.start) begin
      curEntry <= cfgTable[regionSel];
      elapsed  <= '0;
    end else if (ctl.count && elapsed != LAST) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign laneUpper = ctl.laneEn & ~syncB[1];
  assign laneLower = ctl.laneEn & ~syncB[0];

  // counter only moves on a control strobe (R7)
  p_count_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.start && !ctl.count) |=> $stable(elapsed));

  // lanes only while a cycle is active (R2)
  p_lanes_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    (laneUpper || laneLower) |-> ctl.laneEn);
endmodule

// File: rtl/bus_ack_ctrl.sv
module bus_ack_ctrl
  import bus_ack_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             asSync,
  input  logic             dsIdle,
  input  regionCfg_t       curEntry,
  input  logic [CNT_W-1:0] elapsed,
  output ctrlStrobe_t      ctl,
  output logic             dtackN,
  output logic             berrN
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  busState_t state, nextState;
  logic allHigh;

  assign allHigh = asSync & dsIdle;

  always_comb begin
    nextState  = state;
    ctl        = '0;
    ctl.laneEn = (state == ST_WAIT) || (state == ST_ACK);
    unique case (state)
      ST_IDLE: if (!asSync) begin
        nextState = ST_WAIT;
        ctl.start = 1'b1;
      end
      ST_WAIT: begin
        ctl.count = 1'b1;
        if (elapsed == LAST)
          nextState = ST_BERR;
        else if (!curEntry.unmapped && elapsed == CNT_W'(curEntry.waitCount))
          nextState = ST_ACK;
      end
      ST_ACK:     if (allHigh) nextState = ST_RECOVER;
      ST_BERR:    if (asSync)  nextState = ST_RECOVER;
      ST_RECOVER: if (allHigh) nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign dtackN = (state != ST_ACK);
  assign berrN  = (state != ST_BERR);

  p_ack_mapped_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dtackN) |-> !$past(curEntry.unmapped));

  p_ack_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dtackN) |-> $past(elapsed) == CNT_W'($past(curEntry.waitCount)));

  p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!dtackN && !allHigh) |=> !dtackN);

  p_berr_timeout_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(berrN) |-> $past(elapsed) == LAST);

  p_berr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!berrN && !asSync) |=> !berrN);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(!dtackN && !berrN));

  p_recover_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dtackN) |=> (dtackN && berrN));
endmodule

// File: rtl/bus_ack_gen.sv
module bus_ack_gen
  import bus_ack_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                asN,
  input  logic                udsN,
  input  logic                ldsN,
  input  logic [REGION_W-1:0] regionSel,
  input  logic                cfgWe,
  input  logic [REGION_W-1:0] cfgIdx,
  input  logic [WAIT_W-1:0]   cfgWait,
  input  logic                cfgUnmapped,
  output logic                dtackN,
  output logic                berrN,
  output logic                laneUpper,
  output logic                laneLower
);
  ctrlStrobe_t      ctl;
  logic             asSync, dsIdle;
  regionCfg_t       curEntry;
  logic [CNT_W-1:0] elapsed;

  bus_ack_datapath u_dp (
    .clk, .rstN, .asN, .udsN, .ldsN, .regionSel,
    .cfgWe, .cfgIdx, .cfgWait, .cfgUnmapped,
    .ctl, .asSync, .dsIdle, .curEntry, .elapsed,
    .laneUpper, .laneLower
  );

  bus_ack_ctrl u_ctrl (
    .clk, .rstN, .asSync, .dsIdle, .curEntry, .elapsed,
    .ctl, .dtackN, .berrN
  );
endmodule

// File: tb/bus_ack_gen_tb_top.sv
module bus_ack_gen_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic asN = 1'b1, udsN = 1'b1, ldsN = 1'b1;
  logic [1:0] regionSel = '0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgIdx = '0;
  logic [3:0] cfgWait = '0;
  logic cfgUnmapped = 1'b0;
  logic dtackN, berrN, laneUpper, laneLower;

  int vectors = 0;
  int fails = 0;
  int exclViol = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_ack_gen dut_i (
    .clk, .rstN, .asN, .udsN, .ldsN, .regionSel,
    .cfgWe, .cfgIdx, .cfgWait, .cfgUnmapped,
    .dtackN, .berrN, .laneUpper, .laneLower
  );

  always @(negedge clk) begin
    if (rstN && !dtackN && !berrN) exclViol++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [1:0] idx, input logic [3:0] w, input logic unm);
    cfgWe = 1'b1; cfgIdx = idx; cfgWait = w; cfgUnmapped = unm;
    waitEdges(1);
    cfgWe = 1'b0;
  endtask

  // starts a cycle at a falling edge and checks the acknowledge timing
  task automatic startAndAck(input string req, input logic [1:0] rg, input int w,
                             input logic u, input logic l);
    regionSel = rg; asN = 1'b0; udsN = u; ldsN = l;
    waitEdges(3 + w);
    check({req, " ack not early"}, dtackN, 1'b1);
    waitEdges(1);
    check({req, " ack due"}, dtackN, 1'b0);
  endtask

  task automatic releaseAll(input string req);
    asN = 1'b1; udsN = 1'b1; ldsN = 1'b1;
    waitEdges(2);
    check({req, " ack held through sync"}, dtackN, 1'b0);
    waitEdges(1);
    check({req, " ack released"}, dtackN, 1'b1);
  endtask

  task automatic testReset();
    check("R1 dtackN", dtackN, 1'b1);
    check("R1 berrN", berrN, 1'b1);
    check("R1 lanes", {laneUpper, laneLower}, 2'b00);
  endtask

  task automatic testDefaultZeroWait();
    startAndAck("R5 R3 default region2", 2'd2, 0, 1'b0, 1'b0);
    check("R2 word lanes", {laneUpper, laneLower}, 2'b11);
    releaseAll("R6 zero wait");
    waitEdges(2);
  endtask

  task automatic testWaitStates();
    writeCfg(2'd1, 4'd5, 1'b0);
    writeCfg(2'd2, 4'd15, 1'b0);
    startAndAck("R4 wait5", 2'd1, 5, 1'b0, 1'b1);
    check("R2 upper lane", {laneUpper, laneLower}, 2'b10);
    releaseAll("R6 wait5");
    waitEdges(2);
    startAndAck("R4 wait15", 2'd2, 15, 1'b1, 1'b0);
    check("R2 lower lane", {laneUpper, laneLower}, 2'b01);
    releaseAll("R6 wait15");
    waitEdges(2);
  endtask

  task automatic testHoldUpper();
    startAndAck("R3 region0", 2'd0, 0, 1'b0, 1'b0);
    asN = 1'b1; ldsN = 1'b1;
    waitEdges(6);
    check("R6 upper still low", dtackN, 1'b0);
    udsN = 1'b1;
    waitEdges(2);
    check("R6 held until sync", dtackN, 1'b0);
    waitEdges(1);
    check("R6 released", dtackN, 1'b1);
    waitEdges(2);
  endtask

  task automatic testUnmapped();
    bit sawAck = 1'b0;
    writeCfg(2'd3, 4'd0, 1'b1);
    regionSel = 2'd3; asN = 1'b0; udsN = 1'b0; ldsN = 1'b0;
    for (int i = 0; i < 66; i++) begin
      waitEdges(1);
      if (!dtackN) sawAck = 1'b1;
    end
    check("R7 no ack unmapped", sawAck, 1'b0);
    check("R7 berr not early", berrN, 1'b1);
    waitEdges(1);
    check("R7 berr due", berrN, 1'b0);
    udsN = 1'b1; ldsN = 1'b1;
    waitEdges(10);
    check("R8 berr held while asN low", berrN, 1'b0);
    check("R9 no ack during berr", dtackN, 1'b1);
    udsN = 1'b0;
    asN = 1'b1;
    waitEdges(2);
    check("R8 berr held through sync", berrN, 1'b0);
    waitEdges(1);
    check("R8 berr released", berrN, 1'b1);
    udsN = 1'b1;
    waitEdges(3);
  endtask

  task automatic testBackToBack();
    startAndAck("R10 first", 2'd1, 5, 1'b0, 1'b0);
    asN = 1'b1; udsN = 1'b1; ldsN = 1'b1;
    waitEdges(3);
    check("R10 first released", dtackN, 1'b1);
    startAndAck("R10 second", 2'd0, 0, 1'b1, 1'b0);
    releaseAll("R10 second");
    waitEdges(2);
  endtask

  task automatic testRuntimeChange();
    writeCfg(2'd1, 4'd2, 1'b0);
    startAndAck("R5 rewritten region1", 2'd1, 2, 1'b0, 1'b0);
    releaseAll("R5 rewritten");
    waitEdges(2);
  endtask

  initial begin
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);
    testReset();
    testDefaultZeroWait();
    testWaitStates();
    testHoldUpper();
    testUnmapped();
    testBackToBack();
    testRuntimeChange();
    check("R9 ack and berr exclusive", exclViol, 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule